// File: doc/BRIEF.md
# Triangle Channel Register Front End

This block receives byte writes from a processor aimed at the three registers of a triangle-wave sound channel and keeps the channel state that those writes set up. The state is an 11-bit timer period, a 7-bit linear-counter reload value with a halt/control flag, a pending-reload flag for the linear counter, and a length counter. The length counter is loaded from a 32-entry lookup table held as a parameter. A channel-enable level comes from the shared status register. A one-cycle length-clock strobe comes from the frame sequencer.

Downstream stages read the outputs: the waveform step logic, the timer down-counter and the linear counter. Those stages are not part of this block. The linear counter returns a one-cycle `reloadTaken` pulse once it has used the pending reload flag.

The length counter reacts to four sources. In order of strength they are the channel-enable level, a table load from a register write, and a decrement from the length clock. The fourth is a race rule: a table load is refused when it lands in the same cycle as a length clock while the count is nonzero.

Top module: `triLenTop`

## Requirements
- R1: When `rstN` is low, the block clears timer period, linear reload value, halt flag, reload flag and length count. `chanActive` is low.
- R2: A write to offset 0 has two effects. Data bit 7 becomes the halt flag. Data bits 6:0 become the linear reload value.
- R3: A write to offset 2 replaces timer period bits 7:0 with the data byte. Timer bits 10:8 are left unchanged.
- R4: A write to offset 3 replaces timer period bits 10:8 with data bits 2:0. Timer bits 7:0 are left unchanged.
- R5: A write to offset 3 while `chanEnable` is high loads the length count from the table entry selected by data bits 7:3. With the default table, index 1 gives 254, index 0 gives 10 and index 31 gives 30.
- R6: A write to offset 3 while `chanEnable` is low leaves the length count at zero.
- R7: A write to offset 3 does not load the table when it lands in the same cycle as a `lengthClock` pulse and the count is nonzero. In that case the clock acts as if no write had happened. If the count is zero, the load takes place.
- R8: Every write to offset 3 sets the linear reload flag. A `reloadTaken` pulse clears the flag. When both happen in the same cycle, the set wins.
- R9: While `chanEnable` is low, the length count is forced to zero on the next clock edge.
- R10: A `lengthClock` pulse with the halt flag clear and a nonzero count lowers the count by one. When the halt flag is set, or the count is zero, the count holds.
- R11: `chanActive` is high exactly when the length count is nonzero.
- R12: A write to offset 1 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register offset within the channel |
| wrData | input | 8 | Write data byte |
| chanEnable | input | 1 | Channel enable level from the status register |
| lengthClock | input | 1 | One-cycle length-counter clock from the frame sequencer |
| reloadTaken | input | 1 | Linear counter has consumed the reload flag |
| timerPeriod | output | 11 | Timer period |
| linearReload | output | 7 | Linear-counter reload value |
| haltFlag | output | 1 | Length halt / linear control flag |
| linearReloadFlag | output | 1 | Pending linear-counter reload |
| lengthValue | output | 8 | Length counter value |
| chanActive | output | 1 | Length counter is nonzero |

## Verification
The assertions are checked on every cycle. They cover the following:
- the count is cleared after the enable drops;
- the count decrements under an unhalted clock;
- the count never rises when a length clock meets a write and the count is nonzero;
- the reload flag is set by an offset-3 write;
- the upper timer bits are preserved across an offset-2 write.

The bench scenarios are needed for the rest:
- the actual table values reached through the index field;
- the refused write while the channel is disabled;
- the zero-count exception to the race rule;
- the halt and zero holds;
- the set-beats-clear ordering of the reload flag;
- offset-1 writes being ignored.

// File: rtl/triLenPkg.sv
package triLenPkg;
  localparam int TIMER_W = 11;
  localparam int LIN_W   = 7;
  localparam int LEN_W   = 8;
  localparam int DATA_W  = 8;
  localparam int TBL_N   = 32;
  localparam int IDX_W   = $clog2(TBL_N);
  localparam int HI_W    = TIMER_W - DATA_W;

  typedef enum logic [1:0] {
    OFS_CTRL  = 2'd0,
    OFS_NONE  = 2'd1,
    OFS_TLOW  = 2'd2,
    OFS_THIGH = 2'd3
  } regOfs_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrTimerLo;
    logic wrTimerHi;
    logic lenLoad;
    logic lenDec;
    logic lenClear;
    logic flagSet;
    logic flagClear;
  } triStrobes_t;
endpackage

// File: rtl/triLenCtrl.sv
module triLenCtrl
  import triLenPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic        chanEnable,
  input  logic        lengthClock,
  input  logic        reloadTaken,
  input  logic        lenNonZero,
  input  logic        haltNow,
  output triStrobes_t strobes
);
  logic hitCtrl, hitLo, hitHi, raceBlock;

  always_comb begin
    hitCtrl   = wrEn && (regOfs_e'(wrAddr) == OFS_CTRL);
    hitLo     = wrEn && (regOfs_e'(wrAddr) == OFS_TLOW);
    hitHi     = wrEn && (regOfs_e'(wrAddr) == OFS_THIGH);
    raceBlock = lengthClock && lenNonZero;

    strobes           = '0;
    strobes.wrCtrl    = hitCtrl;
    strobes.wrTimerLo = hitLo;
    strobes.wrTimerHi = hitHi;
    strobes.flagSet   = hitHi;
    strobes.flagClear = reloadTaken && !hitHi;
    strobes.lenClear  = !chanEnable;
    strobes.lenLoad   = chanEnable && hitHi && !raceBlock;
    strobes.lenDec    = chanEnable && !strobes.lenLoad && lengthClock
                        && !haltNow && lenNonZero;
  end

  // R10/R5/R9: at most one length action per cycle
  a_r10_one_len_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.lenLoad, strobes.lenDec, strobes.lenClear}));
endmodule

// File: rtl/triLenData.sv
module triLenData
  import triLenPkg::*;
#(
  parameter logic [LEN_W-1:0] LEN_TABLE [TBL_N] = '{default: '0}
) (
  input  logic               clk,
  input  logic               rstN,
  input  triStrobes_t        strobes,
  input  logic [DATA_W-1:0]  wrData,
  output logic [TIMER_W-1:0] timerReg,
  output logic [LIN_W-1:0]   linReg,
  output logic               haltReg,
  output logic               flagReg,
  output logic [LEN_W-1:0]   lenReg
);
  logic [IDX_W-1:0] tblIdx;
  assign tblIdx = wrData[DATA_W-1 -: IDX_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltReg <= 1'b0;
      linReg  <= '0;
    end else if (strobes.wrCtrl) begin
      haltReg <= wrData[DATA_W-1];
      linReg  <= wrData[LIN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerReg <= '0;
    end else begin
      if (strobes.wrTimerLo) timerReg[DATA_W-1:0]       <= wrData;
      if (strobes.wrTimerHi) timerReg[TIMER_W-1:DATA_W] <= wrData[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  flagReg <= 1'b0;
    else if (strobes.flagSet)   flagReg <= 1'b1;
    else if (strobes.flagClear) flagReg <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lenReg <= '0;
    else if (strobes.lenClear) lenReg <= '0;
    else if (strobes.lenLoad)  lenReg <= LEN_TABLE[tblIdx];
    else if (strobes.lenDec)   lenReg <= lenReg - 1'b1;
  end

  // R2: control write lands in halt and reload value
  a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrCtrl |=> (haltReg == $past(wrData[DATA_W-1]))
                       && (linReg == $past(wrData[LIN_W-1:0])));
  // R4: high-timer write keeps low byte
  a_r4_keep_low: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrTimerHi && !strobes.wrTimerLo) |=>
      timerReg[DATA_W-1:0] == $past(timerReg[DATA_W-1:0]));
endmodule

// File: rtl/triLenTop.sv
module triLenTop
  import triLenPkg::*;
#(
  parameter logic [LEN_W-1:0] LEN_TABLE [TBL_N] = '{
    8'd10, 8'd254, 8'd20, 8'd2,  8'd40,  8'd4,  8'd80, 8'd6,
    8'd160, 8'd8,  8'd60, 8'd10, 8'd14,  8'd12, 8'd26, 8'd14,
    8'd12, 8'd16,  8'd24, 8'd18, 8'd48,  8'd20, 8'd96, 8'd22,
    8'd192, 8'd24, 8'd72, 8'd26, 8'd16,  8'd28, 8'd32, 8'd30}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               chanEnable,
  input  logic               lengthClock,
  input  logic               reloadTaken,
  output logic [TIMER_W-1:0] timerPeriod,
  output logic [LIN_W-1:0]   linearReload,
  output logic               haltFlag,
  output logic               linearReloadFlag,
  output logic [LEN_W-1:0]   lengthValue,
  output logic               chanActive
);
  triStrobes_t strobes;
  logic lenNonZero;

  assign lenNonZero = |lengthValue;
  assign chanActive = lenNonZero;

  triLenCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .chanEnable(chanEnable), .lengthClock(lengthClock),
    .reloadTaken(reloadTaken), .lenNonZero(lenNonZero),
    .haltNow(haltFlag), .strobes(strobes)
  );

  triLenData #(.LEN_TABLE(LEN_TABLE)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .timerReg(timerPeriod), .linReg(linearReload), .haltReg(haltFlag),
    .flagReg(linearReloadFlag), .lenReg(lengthValue)
  );

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    !chanEnable |=> lengthValue == '0);

  a_r7_race_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    (chanEnable && wrEn && wrAddr == 2'd3 && lengthClock && lengthValue != '0)
      |=> lengthValue <= $past(lengthValue));

  a_r10_decrement: assert property (@(posedge clk) disable iff (!rstN)
    (chanEnable && lengthClock && !haltFlag && lengthValue != '0
      && !(wrEn && wrAddr == 2'd3))
      |=> lengthValue == $past(lengthValue) - 1'b1);

  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd3) |=> linearReloadFlag);

  a_r3_keep_high: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd2) |=>
      timerPeriod[TIMER_W-1:DATA_W] == $past(timerPeriod[TIMER_W-1:DATA_W]));
endmodule

// File: tb/triLenTop_bench.sv
module triLenTop_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        chanEnable = 1'b0;
  logic        lengthClock = 1'b0;
  logic        reloadTaken = 1'b0;
  logic [10:0] timerPeriod;
  logic [6:0]  linearReload;
  logic        haltFlag, linearReloadFlag, chanActive;
  logic [7:0]  lengthValue;

  always #10 clk = ~clk;

  triLenTop u_triLenTop (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .chanEnable(chanEnable), .lengthClock(lengthClock),
    .reloadTaken(reloadTaken), .timerPeriod(timerPeriod),
    .linearReload(linearReload), .haltFlag(haltFlag),
    .linearReloadFlag(linearReloadFlag), .lengthValue(lengthValue),
    .chanActive(chanActive)
  );

  typedef struct {
    string      req;
    logic [10:0] tmr;
    logic [7:0]  len;
    logic        h;
    logic [6:0]  lin;
    logic        f;
    logic        act;
  } expItem_t;

  expItem_t   expQ[$];
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  logic [10:0] mTmr = '0;
  logic [7:0]  mLen = '0;
  logic        mHalt = 0;
  logic [6:0]  mLin = '0;
  logic        mFlag = 0;
  bit          en = 0;

  function automatic logic [7:0] lenOf(input logic [4:0] i);
    if (i[0]) return (i == 5'd1) ? 8'd254 : 8'(i - 5'd1);
    case (i[4:1])
      4'd0: return 8'd10;   4'd1: return 8'd20;   4'd2: return 8'd40;
      4'd3: return 8'd80;   4'd4: return 8'd160;  4'd5: return 8'd60;
      4'd6: return 8'd14;   4'd7: return 8'd26;   4'd8: return 8'd12;
      4'd9: return 8'd24;   4'd10: return 8'd48;  4'd11: return 8'd96;
      4'd12: return 8'd192; 4'd13: return 8'd72;  4'd14: return 8'd16;
      default: return 8'd32;
    endcase
  endfunction

  task automatic pushExp(input string req);
    expItem_t it;
    it.req = req; it.tmr = mTmr; it.len = mLen; it.h = mHalt;
    it.lin = mLin; it.f = mFlag; it.act = (mLen != 0);
    expQ.push_back(it);
  endtask

  task automatic step(input bit we, input logic [1:0] a, input logic [7:0] d,
                      input bit lc, input bit tk, input string req);
    logic [7:0] nLen;
    bit wr3;
    wrEn = we; wrAddr = a; wrData = d; lengthClock = lc;
    reloadTaken = tk; chanEnable = en;
    wr3 = we && (a == 2'd3);
    nLen = mLen;
    if (!en) nLen = 0;
    else if (wr3 && !(lc && mLen != 0)) nLen = lenOf(d[7:3]);
    else if (lc && !mHalt && mLen != 0) nLen = mLen - 1;
    @(posedge clk);
    mLen = nLen;
    if (we && a == 2'd0) begin mHalt = d[7]; mLin = d[6:0]; end
    if (we && a == 2'd2) mTmr[7:0] = d;
    if (wr3) begin mTmr[10:8] = d[2:0]; mFlag = 1; end
    else if (tk) mFlag = 0;
    #2;
    pushExp(req);
    wrEn = 0; lengthClock = 0; reloadTaken = 0;
  endtask

  // monitor: compares expected items against the ports
  initial begin
    forever begin
      wait (expQ.size() != 0);
      begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (timerPeriod !== e.tmr || lengthValue !== e.len || haltFlag !== e.h ||
            linearReload !== e.lin || linearReloadFlag !== e.f || chanActive !== e.act) begin
          errors++;
          $display("FAIL %s: got tmr=%h len=%0d h=%b lin=%h f=%b act=%b exp tmr=%h len=%0d h=%b lin=%h f=%b act=%b",
                   e.req, timerPeriod, lengthValue, haltFlag, linearReload,
                   linearReloadFlag, chanActive, e.tmr, e.len, e.h, e.lin, e.f, e.act);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    pushExp("R1 reset state");
    rstN = 1;
    step(1, 2'd0, 8'hA5, 0, 0, "R2 halt set, reload 0x25");
    step(1, 2'd0, 8'h7F, 0, 0, "R2 halt clear, reload 0x7F");
    step(1, 2'd2, 8'h34, 0, 0, "R3 timer low byte");
    step(1, 2'd3, 8'h0D, 0, 0, "R6 disabled write leaves length zero");
    en = 1;
    step(1, 2'd3, 8'h0D, 0, 0, "R5 index1 loads 254, R4 timer high");
    step(1, 2'd2, 8'hFF, 0, 0, "R3 low byte keeps high bits");
    step(0, 2'd0, 8'h00, 0, 1, "R8 reloadTaken clears flag");
    step(1, 2'd3, 8'h0D, 0, 1, "R8 set wins over clear");
    step(0, 2'd0, 8'h00, 1, 0, "R10 decrement");
    step(0, 2'd0, 8'h00, 1, 0, "R10 decrement again");
    step(1, 2'd0, 8'h80, 0, 0, "R2 halt set");
    step(0, 2'd0, 8'h00, 1, 0, "R10 halt holds count");
    step(1, 2'd0, 8'h00, 0, 0, "R2 halt clear");
    step(1, 2'd3, 8'hF8, 1, 0, "R7 race refuses reload");
    step(1, 2'd1, 8'hFF, 0, 0, "R12 offset 1 ignored");
    en = 0;
    step(0, 2'd0, 8'h00, 0, 0, "R9 disable clears, R11 inactive");
    en = 1;
    step(1, 2'd3, 8'h00, 1, 0, "R7 zero count loads despite clock, index0 = 10");
    for (int i = 0; i < 10; i++) step(0, 2'd0, 8'h00, 1, 0, "R10 count down, R11");
    step(0, 2'd0, 8'h00, 1, 0, "R10 zero holds, R11 inactive");
    step(1, 2'd3, 8'hF8, 0, 0, "R5 index31 loads 30");
    wait (expQ.size() == 0);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule